// File: doc/BRIEF.md
# Shared Coprocessor RAM Host Window

This block gives a byte-wide host bus access to the local RAM of an I/O coprocessor. The host first loads a 16-bit RAM pointer, one byte register for each half. It then reads or writes a data register, and each access touches the byte the pointer selects. When auto-increment is enabled, every data access moves the pointer forward by one. A host can therefore load, dump or verify a whole code image with back-to-back data accesses.

A control/status register holds four things:

- a run bit that releases the coprocessor;
- the auto-increment enable;
- a write-only doorbell bit that sends a one-cycle pulse to the coprocessor;
- two event flags that the coprocessor raises.

The two flags are cleared by writing one to them and are merged onto a single host interrupt line.

The block owns a dual-port byte RAM. Its second port is a plain read/write port for the coprocessor. Software also uses one RAM byte as a heartbeat: the coprocessor stores 0xFF there, and the host reads it and writes it back to zero.

Top module: `shram_host_port`

## Requirements
- R1: After reset both pointer bytes read 0x00, the control register reads 0x00, and `host_irq`, `cop_run` and `cop_doorbell` are low.
- R2: Register select 0 writes and reads pointer bits 7:0, and select 1 writes and reads pointer bits 15:8. Writing one half leaves the other half unchanged.
- R3: With select 2, a host write stores `host_wdata` at the pointed byte, and a host read returns that byte combinationally. When control bit 1 (auto-increment) is set, each data access adds one to the pointer, and the pointer wraps from 0xFFFF to 0x0000.
- R4: With control bit 1 clear, data accesses leave the pointer unchanged. Control bit 1 reads back as written.
- R5: A control write (select 3) loads bit 0 into the run bit. `cop_run` follows that bit from the next cycle, and bit 0 reads back as written.
- R6: A control write with bit 2 set drives `cop_doorbell` high for exactly the following cycle. Bit 2 always reads back as 0.
- R7: A high `cop_flag_set[n]` sets flag n, which reads at control bit 4+n. `host_irq` is high whenever any flag is set.
- R8: A control write with bit 4+n set clears flag n, and a zero in that bit leaves the flag unchanged. When the last set flag is cleared, `host_irq` is low from the cycle after the write.
- R9: If `cop_flag_set[n]` is high in the same cycle as a host write that clears flag n, the flag stays set.
- R10: The coprocessor port writes with `cop_we` and reads `cop_rdata` combinationally. If the host and the coprocessor write the same byte in the same cycle, the host value is kept. A heartbeat byte of 0xFF written by the coprocessor reads as 0xFF at the host, and after the host writes zero the coprocessor reads 0x00.
- R11: The RAM is indexed by the low RAM_AW pointer bits, so pointer values that differ only above those bits address the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host write |
| host_rd | input | 1 | Host read |
| host_reg | input | 2 | Register select: 0 ptr low, 1 ptr high, 2 data, 3 control |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (0 when not reading) |
| host_irq | output | 1 | OR of the event flags |
| cop_run | output | 1 | Coprocessor run enable |
| cop_doorbell | output | 1 | One-cycle doorbell pulse |
| cop_flag_set | input | NUM_FLAGS | Coprocessor raises event flags |
| cop_we | input | 1 | Coprocessor RAM write |
| cop_addr | input | RAM_AW | Coprocessor RAM address |
| cop_wdata | input | 8 | Coprocessor write byte |
| cop_rdata | output | 8 | Coprocessor read byte |

## Verification
Two pairs of functions can act in the same cycle. In the first, a coprocessor flag raise meets a host control write that clears the same flag. The bench drives both on one clock edge and expects the flag to survive and the interrupt to stay high. In the second, both ports write one RAM byte on the same edge. The bench expects the host byte, read back through the coprocessor port. Around these cases, the bench sweeps the whole RAM through the auto-increment path in both directions and walks every combination of flag state and clear mask.

// File: rtl/shram_pkg.sv
package shram_pkg;
   typedef enum logic [1:0] {
      SEL_PLO  = 2'd0,
      SEL_PHI  = 2'd1,
      SEL_DATA = 2'd2,
      SEL_CTRL = 2'd3
   } hreg_e;

   localparam int BIT_RUN   = 0;
   localparam int BIT_AINC  = 1;
   localparam int BIT_BELL  = 2;
   localparam int BIT_FLAG0 = 4;
endpackage

// File: rtl/shram_addr_ctr.sv
module shram_addr_ctr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic [7:0]        wbyte,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_w
         $error("shram_addr_ctr: ADDR_W must be 9..16");
      end
   endgenerate

   logic unused_hi_bits;
   assign unused_hi_bits = ^wbyte;

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr <= '0;
      else if (ld_lo)
         addr[7:0] <= wbyte;
      else if (ld_hi)
         addr[ADDR_W-1:8] <= wbyte[HI_W-1:0];
      else if (step)
         addr <= addr + 1'b1;
   end

   AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> addr[ADDR_W-1:8] == $past(addr[ADDR_W-1:8])); // R2
   AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hi && !ld_lo) |=> addr[7:0] == $past(addr[7:0])); // R2
   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !ld_lo && !ld_hi && addr == '1) |=> addr == '0); // R3
   AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_lo && !ld_hi && !step) |=> $stable(addr)); // R4
endmodule

// File: rtl/shram_ctrl.sv
module shram_ctrl
   import shram_pkg::*;
#(
   parameter int NUM_FLAGS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr,
   input  logic [7:0]           wbyte,
   input  logic [NUM_FLAGS-1:0] flag_set,
   output logic                 run,
   output logic                 ainc,
   output logic                 bell,
   output logic [NUM_FLAGS-1:0] flags,
   output logic [7:0]           status
);
   generate
      if (NUM_FLAGS < 1 || NUM_FLAGS > 4) begin : g_bad_n
         $error("shram_ctrl: NUM_FLAGS must be 1..4");
      end
   endgenerate

   logic unused_wbits;
   assign unused_wbits = ^wbyte;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run   <= 1'b0;
         ainc  <= 1'b0;
         bell  <= 1'b0;
         flags <= '0;
      end else begin
         bell <= wr && wbyte[BIT_BELL];
         if (wr) begin
            run  <= wbyte[BIT_RUN];
            ainc <= wbyte[BIT_AINC];
         end
         for (int i = 0; i < NUM_FLAGS; i++) begin
            if (flag_set[i])
               flags[i] <= 1'b1;
            else if (wr && wbyte[BIT_FLAG0+i])
               flags[i] <= 1'b0;
         end
      end
   end

   always_comb begin
      status = '0;
      status[BIT_RUN]  = run;
      status[BIT_AINC] = ainc;
      for (int i = 0; i < NUM_FLAGS; i++)
         status[BIT_FLAG0+i] = flags[i];
   end

   AST_RUN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> run == $past(wbyte[BIT_RUN])); // R5
   AST_BELL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      bell |-> $past(wr && wbyte[BIT_BELL])); // R6
   AST_BELL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      status[BIT_BELL] == 1'b0); // R6

   genvar g;
   generate
      for (g = 0; g < NUM_FLAGS; g++) begin : g_flag_chk
         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            flag_set[g] |=> flags[g]); // R9
         AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && wbyte[BIT_FLAG0+g] && !flag_set[g]) |=> !flags[g]); // R8
         AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_set[g] && !(wr && wbyte[BIT_FLAG0+g])) |=> $stable(flags[g])); // R8
      end
   endgenerate
endmodule

// File: rtl/shram_dpram.sv
module shram_dpram #(
   parameter int AW        = 8,
   parameter bit HOST_WINS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_we,
   input  logic [AW-1:0] h_addr,
   input  logic [7:0]    h_wdata,
   output logic [7:0]    h_rdata,
   input  logic          c_we,
   input  logic [AW-1:0] c_addr,
   input  logic [7:0]    c_wdata,
   output logic [7:0]    c_rdata
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("shram_dpram: AW must be 1..12");
      end
   endgenerate

   logic [7:0] mem [DEPTH];
   logic       clash;

   assign clash   = h_we && c_we && (h_addr == c_addr);
   assign h_rdata = mem[h_addr];
   assign c_rdata = mem[c_addr];

   generate
      if (HOST_WINS) begin : g_host_pri
         always_ff @(posedge clk) begin
            if (h_we)
               mem[h_addr] <= h_wdata;
            if (c_we && !clash)
               mem[c_addr] <= c_wdata;
         end
         AST_CLASH_HOST: assert property (@(posedge clk) disable iff (!rst_n)
            clash |=> mem[$past(h_addr)] == $past(h_wdata)); // R10
      end else begin : g_cop_pri
         always_ff @(posedge clk) begin
            if (c_we)
               mem[c_addr] <= c_wdata;
            if (h_we && !clash)
               mem[h_addr] <= h_wdata;
         end
         AST_CLASH_COP: assert property (@(posedge clk) disable iff (!rst_n)
            clash |=> mem[$past(c_addr)] == $past(c_wdata)); // R10
      end
   endgenerate
endmodule

// File: rtl/shram_host_port.sv
module shram_host_port
   import shram_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int RAM_AW    = 8,
   parameter int NUM_FLAGS = 2,
   parameter bit HOST_WINS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_sel,
   input  logic                 host_wr,
   input  logic                 host_rd,
   input  logic [1:0]           host_reg,
   input  logic [7:0]           host_wdata,
   output logic [7:0]           host_rdata,
   output logic                 host_irq,
   output logic                 cop_run,
   output logic                 cop_doorbell,
   input  logic [NUM_FLAGS-1:0] cop_flag_set,
   input  logic                 cop_we,
   input  logic [RAM_AW-1:0]    cop_addr,
   input  logic [7:0]           cop_wdata,
   output logic [7:0]           cop_rdata
);
   generate
      if (RAM_AW > ADDR_W) begin : g_bad_ram
         $error("shram_host_port: RAM_AW exceeds ADDR_W");
      end
   endgenerate

   logic              wr_hit, rd_hit, data_hit, ctrl_wr, step;
   logic              ainc;
   logic [ADDR_W-1:0] ptr;
   logic [NUM_FLAGS-1:0] flags;
   logic [7:0]        status, ram_q;

   assign wr_hit   = host_sel && host_wr;
   assign rd_hit   = host_sel && host_rd;
   assign data_hit = host_sel && (host_wr || host_rd) && (host_reg == SEL_DATA);
   assign ctrl_wr  = wr_hit && (host_reg == SEL_CTRL);
   assign step     = data_hit && ainc;

   shram_addr_ctr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_lo (wr_hit && host_reg == SEL_PLO),
      .ld_hi (wr_hit && host_reg == SEL_PHI),
      .wbyte (host_wdata),
      .step  (step),
      .addr  (ptr)
   );

   shram_ctrl #(.NUM_FLAGS(NUM_FLAGS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ctrl_wr),
      .wbyte    (host_wdata),
      .flag_set (cop_flag_set),
      .run      (cop_run),
      .ainc     (ainc),
      .bell     (cop_doorbell),
      .flags    (flags),
      .status   (status)
   );

   shram_dpram #(.AW(RAM_AW), .HOST_WINS(HOST_WINS)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .h_we    (wr_hit && host_reg == SEL_DATA),
      .h_addr  (ptr[RAM_AW-1:0]),
      .h_wdata (host_wdata),
      .h_rdata (ram_q),
      .c_we    (cop_we),
      .c_addr  (cop_addr),
      .c_wdata (cop_wdata),
      .c_rdata (cop_rdata)
   );

   always_comb begin
      host_rdata = 8'h00;
      if (rd_hit) begin
         case (host_reg)
            SEL_PLO:  host_rdata = ptr[7:0];
            SEL_PHI:  host_rdata = 8'(ptr[ADDR_W-1:8]);
            SEL_DATA: host_rdata = ram_q;
            default:  host_rdata = status;
         endcase
      end
   end

   assign host_irq = |flags;

   AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && (&host_wdata[BIT_FLAG0 +: NUM_FLAGS]) && cop_flag_set == '0)
      |=> !host_irq); // R8
   AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|cop_flag_set) |=> host_irq); // R7
   AST_DATA_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !(ctrl_wr)) |=> ptr == $past(ptr) + 1'b1); // R3
endmodule

// File: tb/shram_host_port_tb.sv
module shram_host_port_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       host_sel, host_wr, host_rd;
   logic [1:0] host_reg;
   logic [7:0] host_wdata, host_rdata;
   logic       host_irq, cop_run, cop_doorbell;
   logic [1:0] cop_flag_set;
   logic       cop_we;
   logic [7:0] cop_addr, cop_wdata, cop_rdata;

   int n_run  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   shram_host_port u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_sel(host_sel), .host_wr(host_wr), .host_rd(host_rd),
      .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_irq(host_irq), .cop_run(cop_run), .cop_doorbell(cop_doorbell),
      .cop_flag_set(cop_flag_set), .cop_we(cop_we), .cop_addr(cop_addr),
      .cop_wdata(cop_wdata), .cop_rdata(cop_rdata)
   );

   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hw(logic [1:0] r, logic [7:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b1; host_rd = 1'b0;
      host_reg = r; host_wdata = d;
      @(negedge clk);
      host_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic hr(logic [1:0] r, output logic [7:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_rd = 1'b1; host_wr = 1'b0; host_reg = r;
      #1 d = host_rdata;
      @(negedge clk);
      host_sel = 1'b0; host_rd = 1'b0;
   endtask

   task automatic cw(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      cop_we = 1'b1; cop_addr = a; cop_wdata = d;
      @(negedge clk);
      cop_we = 1'b0;
   endtask

   task automatic cr(logic [7:0] a, output logic [7:0] d);
      cop_addr = a;
      #1 d = cop_rdata;
   endtask

   task automatic raise(logic [1:0] f);
      @(negedge clk);
      cop_flag_set = f;
      @(negedge clk);
      cop_flag_set = 2'b00;
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic [1:0] expf;
      host_sel = 0; host_wr = 0; host_rd = 0; host_reg = 0; host_wdata = 0;
      cop_flag_set = 0; cop_we = 0; cop_addr = 0; cop_wdata = 0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      hr(2'd0, v); chk("R1 ptr lo", v, 8'h00);
      hr(2'd1, v); chk("R1 ptr hi", v, 8'h00);
      hr(2'd3, v); chk("R1 ctrl", v, 8'h00);
      chk("R1 irq", host_irq, 0);
      chk("R1 run", cop_run, 0);
      chk("R1 doorbell", cop_doorbell, 0);

      // R2 split pointer bytes
      hw(2'd0, 8'h34); hw(2'd1, 8'h12);
      hr(2'd0, v); chk("R2 lo", v, 8'h34);
      hr(2'd1, v); chk("R2 hi", v, 8'h12);
      hw(2'd0, 8'hAB);
      hr(2'd1, v); chk("R2 hi kept", v, 8'h12);
      hw(2'd1, 8'h56);
      hr(2'd0, v); chk("R2 lo kept", v, 8'hAB);

      // R3/R5 upload full RAM with auto-increment
      hw(2'd3, 8'h03);
      chk("R5 run high", cop_run, 1);
      hr(2'd3, v); chk("R4 ainc reads back", v, 8'h03);
      hw(2'd0, 8'h00); hw(2'd1, 8'h00);
      for (int i = 0; i < 256; i++) hw(2'd2, pat(i));
      hr(2'd0, v); chk("R3 ptr lo after 256", v, 8'h00);
      hr(2'd1, v); chk("R3 ptr hi after 256", v, 8'h01);
      for (int i = 0; i < 256; i++) begin
         cr(8'(i), v);
         chk("R3 upload via cop", v, pat(i));
      end
      // R11 pointer now 0x0100 aliases byte 0; download all
      for (int i = 0; i < 256; i++) begin
         hr(2'd2, v);
         chk("R11 aliased download", v, pat(i));
      end
      hr(2'd1, v); chk("R3 ptr hi after download", v, 8'h02);

      // R3 wrap
      hw(2'd0, 8'hFF); hw(2'd1, 8'hFF);
      hw(2'd2, 8'h5A);
      hr(2'd0, v); chk("R3 wrap lo", v, 8'h00);
      hr(2'd1, v); chk("R3 wrap hi", v, 8'h00);
      cr(8'hFF, v); chk("R3 wrap byte", v, 8'h5A);

      // R4 auto-increment off
      hw(2'd3, 8'h01);
      hw(2'd0, 8'h10);
      hw(2'd2, 8'h77);
      hr(2'd2, v); chk("R4 read same byte", v, 8'h77);
      hr(2'd0, v); chk("R4 ptr held", v, 8'h10);
      hr(2'd3, v); chk("R4 ctrl", v, 8'h01);

      // R5 run clear
      hw(2'd3, 8'h00);
      chk("R5 run low", cop_run, 0);
      hw(2'd3, 8'h03);

      // R6 doorbell pulse
      hw(2'd3, 8'h07);
      chk("R6 doorbell high", cop_doorbell, 1);
      @(negedge clk);
      chk("R6 doorbell one cycle", cop_doorbell, 0);
      hr(2'd3, v); chk("R6 bell reads zero", v, 8'h03);

      // R7 flags
      raise(2'b01);
      hr(2'd3, v); chk("R7 flag0", v, 8'h13);
      chk("R7 irq", host_irq, 1);
      raise(2'b10);
      hr(2'd3, v); chk("R7 both flags", v, 8'h33);

      // R8 sweep of flag state vs clear mask
      for (int s = 0; s < 4; s++) begin
         for (int m = 0; m < 4; m++) begin
            hw(2'd3, 8'h33);
            chk("R8 all cleared irq", host_irq, 0);
            if (s != 0) raise(2'(s));
            hw(2'd3, 8'(8'h03 | (m << 4)));
            expf = 2'(s & ~m);
            chk("R8 irq after clear", host_irq, |expf);
            hr(2'd3, v);
            chk("R8 ctrl after clear", v, {2'b00, expf, 4'h3});
         end
      end

      // R9 set wins over clear in same cycle
      hw(2'd3, 8'h33);
      @(negedge clk);
      cop_flag_set = 2'b01;
      host_sel = 1; host_wr = 1; host_reg = 2'd3; host_wdata = 8'h13;
      @(negedge clk);
      cop_flag_set = 2'b00; host_sel = 0; host_wr = 0;
      hr(2'd3, v); chk("R9 flag survives", v, 8'h13);
      chk("R9 irq", host_irq, 1);

      // R10 collision, host wins
      hw(2'd3, 8'h31);
      hw(2'd0, 8'h20); hw(2'd1, 8'h00);
      @(negedge clk);
      host_sel = 1; host_wr = 1; host_reg = 2'd2; host_wdata = 8'hC3;
      cop_we = 1; cop_addr = 8'h20; cop_wdata = 8'h3C;
      @(negedge clk);
      host_sel = 0; host_wr = 0; cop_we = 0;
      cr(8'h20, v); chk("R10 collision host value", v, 8'hC3);

      // R10 heartbeat byte
      cw(8'h40, 8'hFF);
      hw(2'd0, 8'h40);
      hr(2'd2, v); chk("R10 heartbeat seen", v, 8'hFF);
      hw(2'd2, 8'h00);
      cr(8'h40, v); chk("R10 heartbeat cleared", v, 8'h00);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule